// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This sequential unit carries out one indivisible memory update for a small virtual machine. The caller presents a base address register, a signed 16-bit displacement, a size code, an operation code, and the values of the source register and of register zero. The unit then reads the addressed location over a single-port request/acknowledge memory interface. It works out the new value, writes it back when the operation calls for a store, and reports the old value to one of the two registers.

The port request stays asserted from the first cycle of the read until the write is acknowledged. No other agent can slip an access in between, and this is what makes the update atomic. The unit supports add, and, or, xor, exchange and compare-and-swap. Each of these can run on 4-byte or 8-byte data. A bad size or an unknown code ends the command with an error and no memory traffic.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The access address is `base_i` plus `off_i` sign-extended to the address width. A 4-byte access uses the upper half of the 64-bit data bus with byte enables 0xF0 when address bit 2 is 1. It uses the lower half with 0x0F when that bit is 0. An 8-byte access uses byte enables 0xFF.
- R2: The low byte of `imm_i` selects the combining operation for read-modify-write, with the upper 24 bits zero: 0x00 add, 0x40 or, 0x50 and, 0xA0 xor. The memory location receives (old value) op (source value).
- R3: Bit 0 of `imm_i` set on the four combining codes (0x01, 0x41, 0x51, 0xA1) returns the old memory value on `wb_data_o` with `wb_sel_r0_o` = 0 (source register). With bit 0 clear there is no writeback.
- R4: Code 0xE1 (exchange) stores the source value and returns the old value to the source register.
- R5: Code 0xF1 (compare-and-swap) compares the old value with `r0_i` and stores the source value only when they are equal. In both cases the old value is returned with `wb_sel_r0_o` = 1 (register zero).
- R6: `size_i` = 2'b11 selects 8 bytes and 2'b00 selects 4 bytes. For 4 bytes, arithmetic wraps at 32 bits, the comparison uses only the low 32 bits of `r0_i`, and every returned value is zero-extended to 64 bits.
- R7: `size_i` of 2'b01 or 2'b10, or any other `imm_i` value, completes with `err_o` high together with `done_o`, makes no memory request and gives no writeback.
- R8: The request stays high continuously from the read until the write is acknowledged. `done_o` is a one-cycle pulse that follows the writeback cycle.
- R9: `busy_o` is high from the cycle after an accepted start until the done cycle ends. `start_i` while busy is ignored.
- R10: Reset returns the unit to idle with no request, writeback or done, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a command (taken only when idle) |
| size_i | input | 2 | Access size code |
| imm_i | input | 32 | Operation code |
| base_i | input | 64 | Base address register value |
| off_i | input | 16 | Signed displacement |
| src_i | input | 64 | Source register value |
| r0_i | input | 64 | Register zero value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write strobe (0 = read) |
| mem_addr_o | output | 64 | Memory address |
| mem_wdata_o | output | 64 | Write data |
| mem_be_o | output | 8 | Byte enables |
| mem_rdata_i | input | 64 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Acknowledge for the current access |
| busy_o | output | 1 | Command in progress |
| wb_valid_o | output | 1 | Register writeback strobe |
| wb_sel_r0_o | output | 1 | Writeback target: 1 register zero, 0 source register |
| wb_data_o | output | 64 | Writeback value |
| done_o | output | 1 | Command finished |
| err_o | output | 1 | Command rejected (valid with done) |

## Verification
Let the start be sampled at edge 0 and let each access wait L cycles for its acknowledge. A rejected command raises `done_o` in the first cycle after that edge. A command that stores raises it 4+2L cycles after. A compare-and-swap that misses raises it 3+L cycles after. The writeback strobe comes exactly one cycle before done. The bench drives at falling edges and counts falling edges until done, and it compares the count with these figures for L of 0, 1 and 2. Memory contents and captured writeback values are checked only once done has been seen.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_WB    = 3'd3,
    ST_DONE  = 3'd4
  } amo_state_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_OR   = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_SWAP = 3'd4,
    OP_CAS  = 3'd5
  } amo_op_e;

  typedef struct packed {
    amo_op_e op;
    logic    fetch;
    logic    dword;
  } amo_cmd_t;

  // operation codes in the low byte of the immediate
  localparam logic [7:0] CODE_ADD  = 8'h00;
  localparam logic [7:0] CODE_OR   = 8'h40;
  localparam logic [7:0] CODE_AND  = 8'h50;
  localparam logic [7:0] CODE_XOR  = 8'hA0;
  localparam logic [7:0] CODE_SWAP = 8'hE1;
  localparam logic [7:0] CODE_CAS  = 8'hF1;

  // size codes
  localparam logic [1:0] SZ_WORD  = 2'b00;
  localparam logic [1:0] SZ_DWORD = 2'b11;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       size_i,
  output amo_cmd_t         cmd_o,
  output logic             ok_o
);

  logic       code_ok;
  logic       size_ok;
  logic [7:0] code;

  assign code = imm_i[7:0];

  always_comb begin
    cmd_o.op    = OP_ADD;
    cmd_o.fetch = code[0];
    cmd_o.dword = (size_i == SZ_DWORD);
    code_ok     = 1'b1;
    case (code & 8'hFE)
      CODE_ADD: cmd_o.op = OP_ADD;
      CODE_OR:  cmd_o.op = OP_OR;
      CODE_AND: cmd_o.op = OP_AND;
      CODE_XOR: cmd_o.op = OP_XOR;
      default:  code_ok  = 1'b0;
    endcase
    if (code == CODE_SWAP) begin
      cmd_o.op = OP_SWAP;
      code_ok  = 1'b1;
    end
    if (code == CODE_CAS) begin
      cmd_o.op = OP_CAS;
      code_ok  = 1'b1;
    end
    if (imm_i[IMM_W-1:8] != '0) code_ok = 1'b0;
  end

  assign size_ok = (size_i == SZ_WORD) || (size_i == SZ_DWORD);
  assign ok_o    = code_ok && size_ok;

endmodule

// File: rtl/amo_lane.sv
module amo_lane #(
  parameter int DATA_W = 64
) (
  input  logic                dword_i,
  input  logic                hi_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic [DATA_W-1:0]   new_i,
  output logic [DATA_W-1:0]   old_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W/8-1:0] be_o
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int HALF_BE = DATA_W / 16;

  always_comb begin
    if (dword_i) begin
      old_o   = rdata_i;
      wdata_o = new_i;
      be_o    = '1;
    end else begin
      old_o   = {{HALF_W{1'b0}}, (hi_i ? rdata_i[DATA_W-1:HALF_W] : rdata_i[HALF_W-1:0])};
      wdata_o = {new_i[HALF_W-1:0], new_i[HALF_W-1:0]};
      be_o    = hi_i ? {{HALF_BE{1'b1}}, {HALF_BE{1'b0}}}
                     : {{HALF_BE{1'b0}}, {HALF_BE{1'b1}}};
    end
  end

  // upper half of the new value is zero for a word access
  logic unused_hi;
  assign unused_hi = ^new_i[DATA_W-1:HALF_W];

endmodule

// File: rtl/amo_compute.sv
module amo_compute
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_cmd_t            cmd_i,
  input  logic [DATA_W-1:0]   old_i,
  input  logic [DATA_W-1:0]   src_i,
  input  logic [DATA_W-1:0]   r0_i,
  output logic [DATA_W-1:0]   new_o,
  output logic                store_o,
  output logic                wb_en_o,
  output logic                wb_r0_o
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] src_n;
  logic [DATA_W-1:0] r0_n;
  logic [DATA_W-1:0] raw;
  logic              match;

  assign src_n = cmd_i.dword ? src_i : {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};
  assign r0_n  = cmd_i.dword ? r0_i  : {{HALF_W{1'b0}}, r0_i[HALF_W-1:0]};

  always_comb begin
    case (cmd_i.op)
      OP_ADD:  raw = old_i + src_n;
      OP_OR:   raw = old_i | src_n;
      OP_AND:  raw = old_i & src_n;
      OP_XOR:  raw = old_i ^ src_n;
      default: raw = src_n;
    endcase
  end

  assign new_o   = cmd_i.dword ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
  assign match   = (old_i == r0_n);
  assign store_o = (cmd_i.op != OP_CAS) || match;
  assign wb_en_o = cmd_i.fetch || (cmd_i.op == OP_SWAP) || (cmd_i.op == OP_CAS);
  assign wb_r0_o = (cmd_i.op == OP_CAS);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [1:0]          size_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [DATA_W-1:0]   src_i,
  input  logic [DATA_W-1:0]   r0_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_ack_i,
  output logic                busy_o,
  output logic                wb_valid_o,
  output logic                wb_sel_r0_o,
  output logic [DATA_W-1:0]   wb_data_o,
  output logic                done_o,
  output logic                err_o
);

  localparam int BE_W   = DATA_W / 8;
  localparam int HI_BIT = $clog2(BE_W) - 1;

  amo_state_e        state_q, state_d;
  amo_cmd_t          cmd_q,   dec_cmd;
  logic              dec_ok;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [DATA_W-1:0] src_q,   r0_q;
  logic [DATA_W-1:0] old_q;
  logic              err_q,   err_d;
  logic              take_cmd;
  logic              take_old;
  logic [DATA_W-1:0] rd_old, old_cur, new_val, wdata;
  logic [BE_W-1:0]   be;
  logic              store, wb_en, wb_r0;

  amo_decode #(.IMM_W(IMM_W)) u_dec (
    .imm_i  (imm_i),
    .size_i (size_i),
    .cmd_o  (dec_cmd),
    .ok_o   (dec_ok)
  );

  amo_lane #(.DATA_W(DATA_W)) u_lane (
    .dword_i (cmd_q.dword),
    .hi_i    (addr_q[HI_BIT]),
    .rdata_i (mem_rdata_i),
    .new_i   (new_val),
    .old_o   (rd_old),
    .wdata_o (wdata),
    .be_o    (be)
  );

  // during the read the decision uses the arriving data, later the held copy
  assign old_cur = (state_q == ST_READ) ? rd_old : old_q;

  amo_compute #(.DATA_W(DATA_W)) u_cmp (
    .cmd_i   (cmd_q),
    .old_i   (old_cur),
    .src_i   (src_q),
    .r0_i    (r0_q),
    .new_o   (new_val),
    .store_o (store),
    .wb_en_o (wb_en),
    .wb_r0_o (wb_r0)
  );

  assign addr_d   = base_i + {{(ADDR_W-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign take_cmd = (state_q == ST_IDLE) && start_i;
  assign take_old = (state_q == ST_READ) && mem_ack_i;

  // next-state logic
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = dec_ok ? ST_READ : ST_DONE;
        err_d   = !dec_ok;
      end
      ST_READ:  if (mem_ack_i) state_d = store ? ST_WRITE : ST_WB;
      ST_WRITE: if (mem_ack_i) state_d = ST_WB;
      ST_WB:    state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  // command registers, loaded once per accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '{op: OP_ADD, fetch: 1'b0, dword: 1'b0};
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
    end else if (take_cmd) begin
      cmd_q  <= dec_cmd;
      addr_q <= addr_d;
      src_q  <= src_i;
      r0_q   <= r0_i;
    end
  end

  // old value captured on read acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
    end else if (take_old) begin
      old_q <= rd_old;
    end
  end

  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata;
  assign mem_be_o    = be;
  assign busy_o      = (state_q != ST_IDLE);
  assign wb_valid_o  = (state_q == ST_WB) && wb_en;
  assign wb_sel_r0_o = wb_r0;
  assign wb_data_o   = old_q;
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_DONE) && err_q;

endmodule

// File: rtl/amo_rmw_checker.sv
module amo_rmw_checker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic                mem_ack_i,
  input logic                wb_valid_o,
  input logic                done_o,
  input logic                err_o,
  input logic                busy_o
);

  localparam int HB = DATA_W / 16;

  // R8: an unacknowledged access is held unchanged
  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));

  // R8: the write follows the read without releasing the port
  p_port_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> $past(mem_req_o));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: writeback is followed by done
  p_wb_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |=> done_o);

  // R7: a rejected command finishes without writeback or memory traffic
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && !wb_valid_o && !mem_req_o && !$past(mem_req_o)));

  // R1: byte enables are a full bus or exactly one half
  p_be_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_be_o == '1 ||
                   mem_be_o == {{HB{1'b0}}, {HB{1'b1}}} ||
                   mem_be_o == {{HB{1'b1}}, {HB{1'b0}}}));

  // R9: every request and done fall inside a busy window
  p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o || done_o) |-> busy_o);

endmodule

bind atomic_rmw_unit amo_rmw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .mem_ack_i  (mem_ack_i),
  .wb_valid_o (wb_valid_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .busy_o     (busy_o)
);

// File: tb/sim_atomic_rmw_unit.sv
module sim_atomic_rmw_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic [63:0] base;
    logic [15:0] off;
    logic [1:0]  size;
    logic [31:0] imm;
    logic [63:0] src;
    logic [63:0] r0;
    logic [63:0] minit;
    logic [63:0] mexp;
    logic [3:0]  idx;
    logic        wbv;
    logic        wbr0;
    logic [63:0] wbd;
    logic        err;
    logic        nowr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{64'h40, 16'h0008, 2'b11, 32'h00, 64'h5, 64'h0, 64'h10, 64'h15, 4'd9, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0},
    '{64'h50, 16'hFFF8, 2'b11, 32'h01, 64'h1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd9, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
    '{64'h40, 16'h0008, 2'b11, 32'h51, 64'h0FF0_0FF0_0FF0_0FF0, 64'h0, 64'hF0F0_F0F0_F0F0_F0F0, 64'h00F0_00F0_00F0_00F0, 4'd9, 1'b1, 1'b0, 64'hF0F0_F0F0_F0F0_F0F0, 1'b0, 1'b0},
    '{64'h48, 16'h0000, 2'b11, 32'h40, 64'h34, 64'h0, 64'h1200, 64'h1234, 4'd9, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0},
    '{64'h48, 16'h0000, 2'b11, 32'hA1, 64'h0FF0, 64'h0, 64'hFF00, 64'hF0F0, 4'd9, 1'b1, 1'b0, 64'hFF00, 1'b0, 1'b0},
    '{64'h40, 16'h0000, 2'b00, 32'h01, 64'h1234_5678_0000_0002, 64'h0, 64'hAAAA_AAAA_FFFF_FFFF, 64'hAAAA_AAAA_0000_0001, 4'd8, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0},
    '{64'h44, 16'h0000, 2'b00, 32'hA0, 64'hF, 64'h0, 64'h0000_00FF_1111_1111, 64'h0000_00F0_1111_1111, 4'd8, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0},
    '{64'h48, 16'h0000, 2'b11, 32'hE1, 64'hBEEF, 64'h0, 64'hDEAD, 64'hBEEF, 4'd9, 1'b1, 1'b0, 64'hDEAD, 1'b0, 1'b0},
    '{64'h48, 16'h0000, 2'b11, 32'hF1, 64'h99, 64'h77, 64'h77, 64'h99, 4'd9, 1'b1, 1'b1, 64'h77, 1'b0, 1'b0},
    '{64'h48, 16'h0000, 2'b11, 32'hF1, 64'h99, 64'h78, 64'h77, 64'h77, 4'd9, 1'b1, 1'b1, 64'h77, 1'b0, 1'b1},
    '{64'h40, 16'h000C, 2'b00, 32'hF1, 64'h1_0000_0022, 64'hFFFF_FFFF_8000_0001, 64'h8000_0001_5555_5555, 64'h0000_0022_5555_5555, 4'd9, 1'b1, 1'b1, 64'h8000_0001, 1'b0, 1'b0},
    '{64'h40, 16'h0000, 2'b00, 32'hE1, 64'hFFFF_FFFF_9999_0000, 64'h0, 64'h1111_2222_3333_4444, 64'h1111_2222_9999_0000, 4'd8, 1'b1, 1'b0, 64'h3333_4444, 1'b0, 1'b0},
    '{64'h48, 16'h0000, 2'b01, 32'h00, 64'h1, 64'h0, 64'h5, 64'h5, 4'd9, 1'b0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{64'h48, 16'h0000, 2'b10, 32'h00, 64'h1, 64'h0, 64'h5, 64'h5, 4'd9, 1'b0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{64'h48, 16'h0000, 2'b11, 32'hE0, 64'h1, 64'h0, 64'h5, 64'h5, 4'd9, 1'b0, 1'b0, 64'h0, 1'b1, 1'b0},
    '{64'h48, 16'h0000, 2'b11, 32'h100, 64'h1, 64'h0, 64'h5, 64'h5, 4'd9, 1'b0, 1'b0, 64'h0, 1'b1, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  size_i;
  logic [31:0] imm_i;
  logic [63:0] base_i;
  logic [15:0] off_i;
  logic [63:0] src_i;
  logic [63:0] r0_i;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [7:0]  mem_be_o;
  logic        busy_o, wb_valid_o, wb_sel_r0_o, done_o, err_o;
  logic [63:0] wb_data_o;

  int n_checks;
  int n_fail;

  // memory model
  logic [63:0] mem [16];
  int          lat;
  int          lat_cnt;
  logic        pre_en;
  logic [3:0]  pre_idx;
  logic [63:0] pre_val;

  atomic_rmw_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i), .imm_i(imm_i),
    .base_i(base_i), .off_i(off_i), .src_i(src_i), .r0_i(r0_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_rdata_i(mem_rdata_i),
    .mem_ack_i(mem_ack_i), .busy_o(busy_o), .wb_valid_o(wb_valid_o),
    .wb_sel_r0_o(wb_sel_r0_o), .wb_data_o(wb_data_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_ack_i   = mem_req_o && (lat_cnt == lat);
  assign mem_rdata_i = mem[mem_addr_o[6:3]];

  always @(posedge clk) begin
    if (mem_req_o && !mem_ack_i) lat_cnt <= lat_cnt + 1;
    else                         lat_cnt <= 0;
    if (pre_en) mem[pre_idx] <= pre_val;
    else if (mem_req_o && mem_we_o && mem_ack_i)
      for (int b = 0; b < 8; b++)
        if (mem_be_o[b]) mem[mem_addr_o[6:3]][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [63:0] val);
    pre_en  = 1'b1;
    pre_idx = idx;
    pre_val = val;
    @(negedge clk);
    pre_en  = 1'b0;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.err)             return "R7";
    if (v.imm == 32'hF1)   return "R5";
    if (v.imm == 32'hE1)   return "R4";
    if (v.size == 2'b00)   return "R6";
    if (v.off[15])         return "R1";
    if (v.imm[0])          return "R3";
    return "R2";
  endfunction

  // drives one command at a falling edge and waits for done
  task automatic run(input vec_t v, output int cyc, output logic seen_wb,
                     output logic wb_r0, output logic [63:0] wb_d, output logic saw_err);
    size_i = v.size; imm_i = v.imm; base_i = v.base; off_i = v.off;
    src_i = v.src; r0_i = v.r0; start_i = 1'b1;
    cyc = 0; seen_wb = 1'b0; wb_r0 = 1'b0; wb_d = '0; saw_err = 1'b0;
    while (cyc < 60) begin
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
      if (wb_valid_o) begin
        seen_wb = 1'b1; wb_r0 = wb_sel_r0_o; wb_d = wb_data_o;
      end
      if (done_o) begin
        saw_err = err_o;
        break;
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int    cyc;
    logic  sw;
    logic  sr0;
    logic  serr;
    logic [63:0] sd;
    int    exp_cyc;
    n_checks = 0; n_fail = 0;
    lat = 0; pre_en = 1'b0; pre_idx = '0; pre_val = '0;
    start_i = 1'b0; size_i = '0; imm_i = '0; base_i = '0; off_i = '0; src_i = '0; r0_i = '0;
    rst_n = 1'b0;
    for (int k = 0; k < 16; k++) mem[k] = 64'h0;
    repeat (3) @(negedge clk);
    // reset state: R10
    check("R10", "req in reset", {63'h0, mem_req_o}, 64'h0);
    check("R10", "done in reset", {63'h0, done_o}, 64'h0);
    check("R9",  "busy in reset", {63'h0, busy_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "wb after reset", {63'h0, wb_valid_o}, 64'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v   = VECS[i];
      lat = i % 3;
      preload(v.idx, v.minit);
      run(v, cyc, sw, sr0, sd, serr);
      check(tag_of(v), "err flag", {63'h0, serr}, {63'h0, v.err});
      check(tag_of(v), "wb valid", {63'h0, sw}, {63'h0, v.wbv});
      if (v.wbv) begin
        check(tag_of(v), "wb target", {63'h0, sr0}, {63'h0, v.wbr0});
        check(tag_of(v), "wb data", sd, v.wbd);
      end
      check(tag_of(v), "memory", mem[v.idx], v.mexp);
      exp_cyc = v.err ? 1 : (v.nowr ? 3 + lat : 4 + 2 * lat);
      check("R8", "cycles to done", 64'(cyc), 64'(exp_cyc));
      @(negedge clk);
      check("R9", "idle after done", {63'h0, busy_o}, 64'h0);
    end

    // R9: start while busy is ignored
    lat = 1;
    preload(4'd9, 64'h100);
    size_i = 2'b11; imm_i = 32'h00; base_i = 64'h48; off_i = 16'h0;
    src_i = 64'h1; r0_i = 64'h0; start_i = 1'b1;
    @(negedge clk);
    check("R9", "busy after start", {63'h0, busy_o}, 64'h1);
    imm_i = 32'hA0; src_i = 64'hFFFF;
    while (!done_o) @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "second start ignored", mem[9], 64'h101);
    check("R9", "idle after ignored start", {63'h0, busy_o}, 64'h0);

    // R10: reset in the middle of an operation
    lat = 3;
    preload(4'd9, 64'h200);
    size_i = 2'b11; imm_i = 32'h00; base_i = 64'h48; off_i = 16'h0;
    src_i = 64'h5; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", "req dropped by reset", {63'h0, mem_req_o}, 64'h0);
    check("R10", "busy dropped by reset", {63'h0, busy_o}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R10", "no write after reset", mem[9], 64'h200);
    check("R10", "no done after reset", {63'h0, done_o}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule